// File: doc/BRIEF.md
# Sequential Small-Format Floating-Point Adder

This block adds two numbers held in a compact floating-point format. Each operand is a 4-bit two's-complement fraction (binary point after the sign bit, so values -1.000 to +0.875) and a 4-bit two's-complement exponent (-8 to +7). The value of an operand is fraction × 2^exponent. A caller raises `start` with both operands on the inputs. The adder captures them on that edge and works through a sequence of clocked steps:

- equalise the exponents, one shift per cycle;
- add the fractions;
- canonicalise a zero result;
- repair a fraction overflow;
- normalise, one shift per cycle;
- round, going back to repair or normalise again if needed;
- test the exponent range.

Inside the block, fractions carry one spare integer bit and two guard bits below the stored fraction LSB. When the result is ready, `done` rises together with the result fraction, the result exponent and the range flags. `done` stays high until the caller drops `start`. A new operation starts only from the idle state.

Top module: `sfp_adder`

## Requirements
- R1: After reset, `done`, `ovf` and `unf` are low, `sum_frac` is 0000 and `sum_exp` is 1000.
- R2: Operands are captured only on a clock edge where `start` is high in the idle state. Changes on the operand inputs after that edge have no effect on the result.
- R3: While both fractions are nonzero and the exponents differ, the fraction with the smaller exponent is shifted right arithmetically by one place per cycle and its exponent is incremented. Two guard bits are kept and bits shifted past them are dropped.
- R4: A zero sum gives `sum_frac` 0000 with `sum_exp` 1000 (which is -8).
- R5: If one operand fraction is 0000, whatever its exponent, there is no alignment. The result is the other operand after normalisation and rounding, so a normalised nonzero operand comes out unchanged.
- R6: A sum outside the fraction range is shifted right arithmetically by one place and its exponent is incremented.
- R7: A nonzero result is normalised: bit 3 of `sum_frac` differs from bit 2. Each left shift during normalisation decrements the exponent by one.
- R8: Rounding adds half of the fraction LSB to the guard bits and then clears them (round half up). If the rounded value is out of range or no longer normalised, it is repaired or normalised again and then rounded again.
- R9: If the final exponent exceeds +7, `ovf` is high and `sum_exp` holds the low four bits of the true exponent (+8 gives 1000).
- R10: If normalisation would need an exponent below -8, the result is 0000 / 1000 and `unf` is high.
- R11: `done` stays high, with stable outputs, while `start` is held. It falls on the first clock edge at which `start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; sampled in idle, then held until done |
| a_frac | input | FW | First operand fraction, two's complement s.fff |
| a_exp | input | EW | First operand exponent, two's complement |
| b_frac | input | FW | Second operand fraction |
| b_exp | input | EW | Second operand exponent |
| sum_frac | output | FW | Result fraction |
| sum_exp | output | EW | Result exponent |
| done | output | 1 | Result valid |
| ovf | output | 1 | Exponent overflow |
| unf | output | 1 | Exponent underflow, result flushed to zero |

## Verification
A bad alignment count or a wrong guard bit only shows at the ports when `done` next rises, as a fraction or exponent off by one step. The scoreboard catches it at that strobe, fewer than about thirty cycles after `start`. A stuck control state shows up as `done` never rising or never falling, so the handshake checks and the watchdog report it. Scrambling the operand inputs in the middle of an operation exposes a design that reads its inputs after the capture edge.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_ADD,
      ST_FIX,
      ST_NORM,
      ST_ROUND,
      ST_CHECK,
      ST_DONE
   } sfp_state_e;

endpackage

// File: rtl/sfp_align_step.sv
// One alignment step: shift the fraction with the smaller exponent right.
module sfp_align_step #(
   parameter int IW = 7,
   parameter int XW = 6
) (
   input  logic signed [IW-1:0] fa_i,
   input  logic signed [IW-1:0] fb_i,
   input  logic signed [XW-1:0] ea_i,
   input  logic signed [XW-1:0] eb_i,
   output logic signed [IW-1:0] fa_o,
   output logic signed [IW-1:0] fb_o,
   output logic signed [XW-1:0] ea_o,
   output logic signed [XW-1:0] eb_o,
   output logic                 done_o
);

   always_comb begin
      fa_o   = fa_i;
      fb_o   = fb_i;
      ea_o   = ea_i;
      eb_o   = eb_i;
      done_o = (fa_i == '0) || (fb_i == '0) || (ea_i == eb_i);
      if (!done_o) begin
         if (ea_i < eb_i) begin
            fa_o = fa_i >>> 1;
            ea_o = ea_i + XW'(1);
         end else begin
            fb_o = fb_i >>> 1;
            eb_o = eb_i + XW'(1);
         end
      end
   end

endmodule

// File: rtl/sfp_post_step.sv
// Classification and candidate next values for the post-add steps.
module sfp_post_step #(
   parameter int IW = 7,
   parameter int XW = 6,
   parameter int EW = 4,
   parameter int GW = 2
) (
   input  logic signed [IW-1:0] s_i,
   input  logic signed [XW-1:0] e_i,
   output logic                 zero_o,
   output logic                 fovf_o,
   output logic                 unnorm_o,
   output logic                 emin_o,
   output logic signed [IW-1:0] rsh_s_o,
   output logic signed [XW-1:0] rsh_e_o,
   output logic signed [IW-1:0] lsh_s_o,
   output logic signed [XW-1:0] lsh_e_o,
   output logic signed [IW-1:0] rnd_s_o
);

   localparam int EMIN_I = -(1 << (EW - 1));

   assign zero_o   = (s_i == '0);
   assign fovf_o   = s_i[IW-1] ^ s_i[IW-2];
   assign unnorm_o = (s_i[IW-2] == s_i[IW-3]);
   assign emin_o   = (e_i == XW'(EMIN_I));
   assign rsh_s_o  = s_i >>> 1;
   assign rsh_e_o  = e_i + XW'(1);
   assign lsh_s_o  = s_i <<< 1;
   assign lsh_e_o  = e_i - XW'(1);

   generate
      if (GW > 0) begin : g_round
         logic signed [IW-1:0] biased;
         assign biased  = s_i + IW'(1 << (GW - 1));
         assign rnd_s_o = {biased[IW-1:GW], {GW{1'b0}}};
      end else begin : g_trunc
         assign rnd_s_o = s_i;
      end
   endgenerate

endmodule

// File: rtl/sfp_adder.sv
module sfp_adder
   import sfp_pkg::*;
#(
   parameter int FW = 4,
   parameter int EW = 4,
   parameter int GW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [FW-1:0] a_frac,
   input  logic [EW-1:0] a_exp,
   input  logic [FW-1:0] b_frac,
   input  logic [EW-1:0] b_exp,
   output logic [FW-1:0] sum_frac,
   output logic [EW-1:0] sum_exp,
   output logic          done,
   output logic          ovf,
   output logic          unf
);

   localparam int IW     = FW + 1 + GW;
   localparam int XW     = EW + 2;
   localparam int EMIN_I = -(1 << (EW - 1));
   localparam int EMAX_I = (1 << (EW - 1)) - 1;

   initial begin
      assert (FW >= 2) else $error("sfp_adder: FW must be at least 2");
      assert (EW >= 2) else $error("sfp_adder: EW must be at least 2");
      assert (GW <= 8) else $error("sfp_adder: GW must not exceed 8");
   end

   sfp_state_e           state;
   logic signed [IW-1:0] fa, fb;
   logic signed [XW-1:0] ea, eb;

   logic signed [IW-1:0] al_fa, al_fb;
   logic signed [XW-1:0] al_ea, al_eb;
   logic                 al_done;

   logic                 po_zero, po_fovf, po_unnorm, po_emin;
   logic signed [IW-1:0] po_rsh_s, po_lsh_s, po_rnd_s;
   logic signed [XW-1:0] po_rsh_e, po_lsh_e;

   sfp_align_step #(.IW(IW), .XW(XW)) u_align (
      .fa_i(fa), .fb_i(fb), .ea_i(ea), .eb_i(eb),
      .fa_o(al_fa), .fb_o(al_fb), .ea_o(al_ea), .eb_o(al_eb),
      .done_o(al_done)
   );

   sfp_post_step #(.IW(IW), .XW(XW), .EW(EW), .GW(GW)) u_post (
      .s_i(fa), .e_i(ea),
      .zero_o(po_zero), .fovf_o(po_fovf), .unnorm_o(po_unnorm),
      .emin_o(po_emin),
      .rsh_s_o(po_rsh_s), .rsh_e_o(po_rsh_e),
      .lsh_s_o(po_lsh_s), .lsh_e_o(po_lsh_e),
      .rnd_s_o(po_rnd_s)
   );

   assign done = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fa       <= '0;
         fb       <= '0;
         ea       <= '0;
         eb       <= '0;
         sum_frac <= '0;
         sum_exp  <= EW'(EMIN_I);
         ovf      <= 1'b0;
         unf      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  fa    <= IW'($signed(a_frac)) <<< GW;
                  fb    <= IW'($signed(b_frac)) <<< GW;
                  ea    <= XW'($signed(a_exp));
                  eb    <= XW'($signed(b_exp));
                  ovf   <= 1'b0;
                  unf   <= 1'b0;
                  state <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               fa <= al_fa;
               fb <= al_fb;
               ea <= al_ea;
               eb <= al_eb;
               if (al_done) state <= ST_ADD;
            end
            ST_ADD: begin
               fa <= fa + fb;
               if (fa == '0) ea <= eb;
               state <= ST_FIX;
            end
            ST_FIX: begin
               if (po_zero) begin
                  sum_frac <= '0;
                  sum_exp  <= EW'(EMIN_I);
                  state    <= ST_DONE;
               end else begin
                  if (po_fovf) begin
                     fa <= po_rsh_s;
                     ea <= po_rsh_e;
                  end
                  state <= ST_NORM;
               end
            end
            ST_NORM: begin
               if (!po_unnorm) begin
                  state <= ST_ROUND;
               end else if (po_emin) begin
                  sum_frac <= '0;
                  sum_exp  <= EW'(EMIN_I);
                  unf      <= 1'b1;
                  state    <= ST_DONE;
               end else begin
                  fa <= po_lsh_s;
                  ea <= po_lsh_e;
               end
            end
            ST_ROUND: begin
               fa    <= po_rnd_s;
               state <= ST_CHECK;
            end
            ST_CHECK: begin
               if (po_fovf || po_unnorm) begin
                  state <= ST_FIX;
               end else begin
                  sum_frac <= fa[IW-2 -: FW];
                  sum_exp  <= ea[EW-1:0];
                  ovf      <= (ea > XW'(EMAX_I));
                  state    <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (!start) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sfp_adder_chk.sv
module sfp_adder_chk #(
   parameter int FW = 4,
   parameter int EW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [FW-1:0] sum_frac,
   input logic [EW-1:0] sum_exp,
   input logic          done,
   input logic          ovf,
   input logic          unf
);

   localparam logic [EW-1:0] ZEXP = {1'b1, {(EW-1){1'b0}}};

   p_zero_canon_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sum_frac == '0) |-> (sum_exp == ZEXP));

   p_normalised_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sum_frac != '0) |-> (sum_frac[FW-1] != sum_frac[FW-2]));

   p_flags_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && unf));

   p_flush_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unf) |-> (sum_frac == '0 && sum_exp == ZEXP));

   p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> done);

   p_done_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);

   p_result_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> ($stable(sum_frac) && $stable(sum_exp)));

endmodule

bind sfp_adder sfp_adder_chk #(.FW(FW), .EW(EW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .sum_frac(sum_frac), .sum_exp(sum_exp),
   .done(done), .ovf(ovf), .unf(unf)
);

// File: tb/sfp_adder_test.sv
`timescale 1ns/1ps
module sfp_adder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] a_frac = '0, a_exp = '0, b_frac = '0, b_exp = '0;
   logic [3:0] sum_frac, sum_exp;
   logic       done, ovf, unf;

   always #10 clk = ~clk;   // 50 MHz

   sfp_adder uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_frac(a_frac), .a_exp(a_exp), .b_frac(b_frac), .b_exp(b_exp),
      .sum_frac(sum_frac), .sum_exp(sum_exp),
      .done(done), .ovf(ovf), .unf(unf)
   );

   int         n_cmp = 0;
   int         n_bad = 0;
   bit         finished = 0;
   logic [9:0] exp_q[$];   // {unf, ovf, exp[3:0], frac[3:0]}
   string      req_q[$];

   task automatic check(string req, string what, int got, int want);
      n_cmp++;
      if (got !== want) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, want);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Integer-scaled model: units of 1/32 (three fraction bits plus two guard bits).
   function automatic logic [9:0] model(logic [3:0] fa, logic [3:0] ea,
                                        logic [3:0] fb, logic [3:0] eb);
      int a = $signed(fa) * 4;
      int b = $signed(fb) * 4;
      int x = $signed(ea);
      int y = $signed(eb);
      int s, e, q;
      logic [3:0] fr, ex;
      if (a == 0) begin s = b; e = y; end
      else if (b == 0) begin s = a; e = x; end
      else begin
         while (x < y) begin a = a >>> 1; x++; end
         while (y < x) begin b = b >>> 1; y++; end
         s = a + b;
         e = x;
      end
      for (int k = 0; k < 8; k++) begin
         if (s == 0) return 10'b00_1000_0000;
         if (s > 31 || s < -32) begin s = s >>> 1; e++; end
         while (s >= -16 && s <= 15) begin
            if (e == -8) return 10'b10_1000_0000;
            s = s * 2;
            e--;
         end
         s = ((s + 2) >>> 2) * 4;
         if (s <= 31 && (s >= 16 || s <= -17)) break;
      end
      q  = s >>> 2;
      fr = q[3:0];
      ex = e[3:0];
      return {1'b0, (e > 7), ex, fr};
   endfunction

   function automatic string label(logic [3:0] fa, logic [3:0] fb, logic [9:0] r);
      if (r[8])                  return "R2/R9";
      if (r[9])                  return "R2/R10";
      if (fa == 0 || fb == 0)    return "R2/R5";
      if (r[3:0] == 0)           return "R2/R4";
      return "R2/R3/R6/R7/R8";
   endfunction

   // Driver: push the expected item, then run the handshake.
   // Operand inputs are scrambled right after capture (R2).
   task automatic drive(logic [3:0] fa, logic [3:0] ea, logic [3:0] fb, logic [3:0] eb,
                        string req, logic [9:0] want, int hold);
      exp_q.push_back(want);
      req_q.push_back(req);
      @(negedge clk);
      a_frac = fa; a_exp = ea; b_frac = fb; b_exp = eb;
      start  = 1'b1;
      @(negedge clk);
      a_frac = ~fa; a_exp = ea + 4'd5; b_frac = fb ^ 4'b0110; b_exp = ~eb;
      do @(negedge clk); while (!done);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         check("R11", "done held with start", int'(done), 1);
      end
      start = 1'b0;
      @(negedge clk);
      if (hold > 0) check("R11", "done after start low", int'(done), 0);
   endtask

   // Monitor: compare at each rising done.
   logic done_d = 1'b0;
   always @(negedge clk) begin
      if (rst_n && done && !done_d) begin
         if (exp_q.size() == 0) begin
            check("R11", "unexpected done", 1, 0);
         end else begin
            logic [9:0] w;
            string      r;
            w = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, "{unf,ovf,exp,frac}", int'({unf, ovf, sum_exp, sum_frac}), int'(w));
         end
      end
      done_d = done;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "done at reset", int'(done), 0);
      check("R1", "ovf at reset", int'(ovf), 0);
      check("R1", "unf at reset", int'(unf), 0);
      check("R1", "frac at reset", int'(sum_frac), 0);
      check("R1", "exp at reset", int'(sum_exp), 8);
      rst_n = 1'b1;

      // Hand-worked cases.
      drive(4'b0100, 4'b0000, 4'b0100, 4'b0000, "R6",  10'b00_0001_0100, 0);
      drive(4'b0011, 4'b0000, 4'b0001, 4'b0011, "R3",  10'b00_0001_0101, 0);
      drive(4'b0111, 4'b0000, 4'b0010, 4'b1110, "R8",  10'b00_0001_0100, 0);
      drive(4'b0111, 4'b0111, 4'b0111, 4'b0111, "R9",  10'b01_1000_0111, 0);
      drive(4'b0010, 4'b1000, 4'b0000, 4'b0000, "R10", 10'b10_1000_0000, 0);
      drive(4'b0011, 4'b0010, 4'b1101, 4'b0010, "R4",  10'b00_1000_0000, 0);
      drive(4'b0000, 4'b0101, 4'b1010, 4'b0011, "R5",  10'b00_0011_1010, 4);
      drive(4'b0001, 4'b0000, 4'b0001, 4'b0000, "R7",  10'b00_1111_0100, 0);
      drive(4'b1111, 4'b0000, 4'b0001, 4'b1110, "R8",  10'b00_1101_1010, 3);

      // All fraction pairs across a set of exponent pairs.
      for (int p = 0; p < 8; p++) begin
         logic [3:0] xa, xb;
         case (p)
            0: begin xa = 4'd0;  xb = 4'd0;  end
            1: begin xa = 4'd0;  xb = 4'd1;  end
            2: begin xa = 4'd1;  xb = 4'd0;  end
            3: begin xa = 4'd2;  xb = 4'hF;  end
            4: begin xa = 4'h8;  xb = 4'h8;  end
            5: begin xa = 4'd7;  xb = 4'd7;  end
            6: begin xa = 4'hB;  xb = 4'hF;  end
            default: begin xa = 4'd3; xb = 4'hC; end
         endcase
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               logic [9:0] m;
               m = model(i[3:0], xa, j[3:0], xb);
               drive(i[3:0], xa, j[3:0], xb, label(i[3:0], j[3:0], m), m, 0);
            end
         end
      end

      // All exponent pairs for two fraction pairs (alignment depths 0..15).
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            logic [9:0] m1, m2;
            m1 = model(4'b0101, i[3:0], 4'b1011, j[3:0]);
            drive(4'b0101, i[3:0], 4'b1011, j[3:0], label(4'b0101, 4'b1011, m1), m1, 0);
            m2 = model(4'b0011, i[3:0], 4'b0110, j[3:0]);
            drive(4'b0011, i[3:0], 4'b0110, j[3:0], label(4'b0011, 4'b0110, m2), m2, 0);
         end
      end

      repeat (4) @(negedge clk);
      check("R11", "pending results", exp_q.size(), 0);
      finish_run();
   end

endmodule